// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit logical address into a physical address by reading two page-table entries from memory. The address is cut into a 12-bit outer index, a 10-bit inner index and a 10-bit offset within a 1 KB page. The outer index selects an entry in the outer table, whose base comes from a base-register input. That entry names the inner table, and the inner index selects the leaf entry there. The leaf entry supplies the frame number. Each entry is checked for validity and write permission before the walk moves on. A failed check ends the walk with a fault that reports the level and the reason.

A requester hands over one address at a time over a valid/ready request port. The requester also states whether the access is a write. The walker reads memory through a port that allows only one outstanding read and accepts any response latency. After the walk, the walker pulses one response carrying either the physical address or the fault details. Only one walk runs at a time, and while it runs the request port is held not-ready.

Top module: `two_level_walker`

## Requirements
- R1: After reset `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first memory read of a walk goes to `ptbr + 4*va[31:20]`, where `ptbr` is the value sampled in the cycle the request is accepted.
- R3: When the outer entry passes its checks, the second read goes to `{outer[31:10], 10'b0} + 4*va[19:10]`.
- R4: When both entries pass, the response has `rsp_fault`=0, `rsp_level`=0 and `rsp_paddr` = `{leaf[31:10], va[9:0]}`.
- R5: An outer entry with bit 0 (valid) clear ends the walk after one read with a fault, level 1 and cause 0 (invalid).
- R6: A leaf entry with bit 0 clear gives a fault with level 2 and cause 0.
- R7: On a write, a valid outer entry with bit 1 (writable) clear gives a fault with level 1 and cause 1 (write-protect) after one read. A clear valid bit takes priority and reports cause 0.
- R8: On a write, a valid leaf entry with bit 1 clear gives a fault with level 2 and cause 1. A read through the same entries succeeds.
- R9: `req_ready` is 0 from the cycle after acceptance until the response has been given. Requests offered in that time start no walk and produce no response.
- R10: `rsp_valid` is a single-cycle pulse, exactly one per accepted request.
- R11: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. The result does not depend on the grant delay or the response delay.
- R12: Changing `ptbr` after acceptance has no effect on the running walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| ptbr | input | 32 | Byte address of the outer table |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_level | output | 2 | 0 on success, else faulting level 1 or 2 |
| rsp_cause | output | 1 | 0 invalid entry, 1 write to read-only |
| rsp_paddr | output | 32 | Physical address on success, 0 on fault |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The bench builds the walker with its default widths: a 32-bit address split 12/10/10 and 32-bit entries. Under this split the all-ones outer index 0xFFF and inner index 0x3FF are reachable. These indices drive the largest offsets the two entry adders ever add, and a 10-bit offset of 0x3FF tests that no offset bit leaks into the frame field. The memory model's grant and return delays range from zero up to several cycles, so both the back-to-back case and a long hold of the read request are exercised.

// File: rtl/walker_pkg.sv
package walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_L1   = 2'd1,
    ST_L2   = 2'd2,
    ST_DONE = 2'd3
  } walk_state_t;

  localparam logic CAUSE_INVALID = 1'b0;
  localparam logic CAUSE_WPROT   = 1'b1;

  localparam logic [1:0] LVL_NONE  = 2'd0;
  localparam logic [1:0] LVL_OUTER = 2'd1;
  localparam logic [1:0] LVL_INNER = 2'd2;

  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITABLE = 1;

endpackage

// File: rtl/walk_entry_addr.sv
module walk_entry_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  assign addr = base + (ADDR_W'(idx) << SHIFT);
endmodule

// File: rtl/walk_pte_decode.sv
module walk_pte_decode
  import walker_pkg::*;
#(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned OFF_W = 10
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  output logic             present,
  output logic             wp_fault,
  output logic [PTE_W-1:0] next_base
);
  logic unused_pte_bits;
  assign unused_pte_bits = ^pte[OFF_W-1:BIT_WRITABLE+1];

  assign present   = pte[BIT_PRESENT];
  assign wp_fault  = is_write & ~pte[BIT_WRITABLE];
  assign next_base = {pte[PTE_W-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/two_level_walker.sv
module two_level_walker
  import walker_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic [PTE_W-1:0] ptbr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_level,
  output logic             rsp_cause,
  output logic [PTE_W-1:0] rsp_paddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PTE_W-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int unsigned L1_W    = VA_W - L2_W - OFF_W;
  localparam int unsigned LOW_W   = L2_W + OFF_W;
  localparam int unsigned E_SHIFT = $clog2(PTE_W / 8);

  walk_state_t      state_q;
  logic [LOW_W-1:0] va_low_q;
  logic             wr_q;
  logic             mreq_v_q;
  logic [PTE_W-1:0] mreq_a_q;
  logic             rsp_v_q, rsp_f_q, rsp_c_q;
  logic [1:0]       rsp_l_q;
  logic [PTE_W-1:0] rsp_pa_q;

  logic [PTE_W-1:0] outer_addr, inner_addr, next_base;
  logic             ent_present, ent_wp;
  logic             data_in;

  walk_entry_addr #(.ADDR_W(PTE_W), .IDX_W(L1_W), .SHIFT(E_SHIFT)) u_outer_addr (
    .base (ptbr),
    .idx  (req_vaddr[VA_W-1:LOW_W]),
    .addr (outer_addr)
  );

  walk_entry_addr #(.ADDR_W(PTE_W), .IDX_W(L2_W), .SHIFT(E_SHIFT)) u_inner_addr (
    .base (next_base),
    .idx  (va_low_q[LOW_W-1:OFF_W]),
    .addr (inner_addr)
  );

  walk_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_decode (
    .pte       (mem_rsp_data),
    .is_write  (wr_q),
    .present   (ent_present),
    .wp_fault  (ent_wp),
    .next_base (next_base)
  );

  assign data_in = mem_rsp_valid & ~mreq_v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      va_low_q <= '0;
      wr_q     <= 1'b0;
      mreq_v_q <= 1'b0;
      mreq_a_q <= '0;
      rsp_v_q  <= 1'b0;
      rsp_f_q  <= 1'b0;
      rsp_c_q  <= CAUSE_INVALID;
      rsp_l_q  <= LVL_NONE;
      rsp_pa_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      if (mreq_v_q && mem_req_ready) mreq_v_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_low_q <= req_vaddr[LOW_W-1:0];
            wr_q     <= req_write;
            mreq_a_q <= outer_addr;
            mreq_v_q <= 1'b1;
            state_q  <= ST_L1;
          end
        end
        ST_L1: begin
          if (data_in) begin
            if (!ent_present || ent_wp) begin
              rsp_v_q  <= 1'b1;
              rsp_f_q  <= 1'b1;
              rsp_l_q  <= LVL_OUTER;
              rsp_c_q  <= ent_present ? CAUSE_WPROT : CAUSE_INVALID;
              rsp_pa_q <= '0;
              state_q  <= ST_DONE;
            end else begin
              mreq_a_q <= inner_addr;
              mreq_v_q <= 1'b1;
              state_q  <= ST_L2;
            end
          end
        end
        ST_L2: begin
          if (data_in) begin
            rsp_v_q <= 1'b1;
            state_q <= ST_DONE;
            if (!ent_present || ent_wp) begin
              rsp_f_q  <= 1'b1;
              rsp_l_q  <= LVL_INNER;
              rsp_c_q  <= ent_present ? CAUSE_WPROT : CAUSE_INVALID;
              rsp_pa_q <= '0;
            end else begin
              rsp_f_q  <= 1'b0;
              rsp_l_q  <= LVL_NONE;
              rsp_c_q  <= CAUSE_INVALID;
              rsp_pa_q <= next_base | PTE_W'(va_low_q[OFF_W-1:0]);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = mreq_v_q;
  assign mem_req_addr  = mreq_a_q;
  assign rsp_valid     = rsp_v_q;
  assign rsp_fault     = rsp_f_q;
  assign rsp_level     = rsp_l_q;
  assign rsp_cause     = rsp_c_q;
  assign rsp_paddr     = rsp_pa_q;

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst) req_ready |-> !mem_req_valid); // R9
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R10
  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R11
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (rst) (rsp_valid && rsp_fault) |-> (rsp_level == LVL_OUTER || rsp_level == LVL_INNER)); // R5
  AST_OK_LEVEL: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_fault) |-> (rsp_level == LVL_NONE)); // R4
endmodule

// File: tb/tb_two_level_walker.sv
`timescale 1ns/1ps
module tb_two_level_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_ready;
  logic [31:0] req_vaddr, ptbr;
  logic        rsp_valid, rsp_fault, rsp_cause;
  logic [1:0]  rsp_level;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;

  always #10 clk = ~clk;

  two_level_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .ptbr(ptbr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_level(rsp_level),
    .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] pt_mem [logic [31:0]];
  int          gnt_delay = 0;
  int          ret_delay = 0;
  int          rd_cnt    = 0;
  logic [31:0] rd_log [0:15];
  int          rsp_cnt   = 0;

  logic        g_fault, g_cause, g_busy_ok, g_pulse_ok, g_back_ready;
  logic [1:0]  g_level;
  logic [31:0] g_paddr, g_rd0, g_rd1;
  int          g_reads, g_rsps;

  always @(posedge clk) if (!rst && rsp_valid) rsp_cnt <= rsp_cnt + 1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // memory model: one read at a time, configurable grant and return delays
  initial begin
    logic [31:0] a;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid) begin
        repeat (gnt_delay) @(negedge clk);
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (ret_delay) @(negedge clk);
        mem_rsp_data  = pt_mem.exists(a) ? pt_mem[a] : 32'h0;
        mem_rsp_valid = 1'b1;
        rd_log[rd_cnt & 15] = a;
        rd_cnt++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  function automatic logic [31:0] outer_at(input logic [31:0] base, input logic [31:0] va);
    return base + {18'b0, va[31:20], 2'b00};
  endfunction

  function automatic logic [31:0] inner_at(input logic [31:0] pte, input logic [31:0] va);
    return {pte[31:10], 10'b0} + {20'b0, va[19:10], 2'b00};
  endfunction

  task automatic map(input logic [31:0] base, input logic [31:0] va, input logic [31:0] pte1, input logic [31:0] pte2);
    pt_mem.delete();
    pt_mem[outer_at(base, va)] = pte1;
    if (pte1[0]) pt_mem[inner_at(pte1, va)] = pte2;
  endtask

  // mode 0 plain, 1 offer requests while busy, 2 change ptbr while busy
  task automatic run_walk(input logic [31:0] va, input logic wr, input int mode);
    int rb, sb, n;
    logic [31:0] saved;
    rb = rd_cnt; sb = rsp_cnt; saved = ptbr;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    g_busy_ok = !req_ready;
    if (mode == 1) begin
      req_valid = 1'b1; req_vaddr = ~va; req_write = 1'b0;
      repeat (2) begin
        @(negedge clk);
        if (req_ready) g_busy_ok = 1'b0;
      end
      req_valid = 1'b0;
    end
    if (mode == 2) ptbr = saved ^ 32'h00F0_0000;
    n = 0;
    while (!rsp_valid && n < 500) begin
      @(negedge clk);
      if (!rsp_valid && req_ready) g_busy_ok = 1'b0;
      n++;
    end
    if (n >= 500) begin
      n_checks++; n_fail++;
      $display("FAIL R10 no response: actual none expected one");
    end
    g_fault = rsp_fault; g_level = rsp_level; g_cause = rsp_cause; g_paddr = rsp_paddr;
    @(negedge clk);
    g_pulse_ok   = !rsp_valid;
    g_back_ready = req_ready;
    repeat (3) @(negedge clk);
    g_reads = rd_cnt - rb;
    g_rsps  = rsp_cnt - sb;
    g_rd0 = rd_log[rb & 15];
    g_rd1 = rd_log[(rb + 1) & 15];
    ptbr = saved;
  endtask

  task automatic expect_ok(input string r, input logic [31:0] va, input logic [31:0] pte1, input logic [31:0] pte2);
    chk(r, "fault", {31'b0, g_fault}, 32'd0);
    chk(r, "level", {30'b0, g_level}, 32'd0);
    chk(r, "paddr", g_paddr, {pte2[31:10], va[9:0]});
    chk(r, "reads", g_reads, 32'd2);
    chk("R2", "outer read addr", g_rd0, outer_at(ptbr, va));
    chk("R3", "inner read addr", g_rd1, inner_at(pte1, va));
    chk("R10", "single pulse", {31'b0, g_pulse_ok}, 32'd1);
    chk("R10", "one response", g_rsps, 32'd1);
  endtask

  task automatic expect_fault(input string r, input logic [1:0] lvl, input logic cause, input int reads);
    chk(r, "fault", {31'b0, g_fault}, 32'd1);
    chk(r, "level", {30'b0, g_level}, {30'b0, lvl});
    chk(r, "cause", {31'b0, g_cause}, {31'b0, cause});
    chk(r, "paddr", g_paddr, 32'd0);
    chk(r, "reads", g_reads, reads);
    chk("R10", "one response", g_rsps, 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1", "mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_read_ok;
    logic [31:0] va = {12'h123, 10'h0AB, 10'h155};
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0002_0401, 32'hABCD_E801);
    run_walk(va, 1'b0, 0);
    expect_ok("R4", va, 32'h0002_0401, 32'hABCD_E801);
  endtask

  task automatic t_write_ok;
    logic [31:0] va = {12'h0F0, 10'h3C1, 10'h2AA};
    ptbr = 32'h0040_0000;
    map(ptbr, va, 32'h0005_0003, 32'h1234_5403);
    run_walk(va, 1'b1, 0);
    expect_ok("R4", va, 32'h0005_0003, 32'h1234_5403);
  endtask

  task automatic t_outer_invalid;
    logic [31:0] va = {12'h555, 10'h111, 10'h001};
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0002_0402, 32'h0);
    run_walk(va, 1'b0, 0);
    expect_fault("R5", 2'd1, 1'b0, 1);
    run_walk(va, 1'b1, 0);
    expect_fault("R7", 2'd1, 1'b0, 1);
  endtask

  task automatic t_inner_invalid;
    logic [31:0] va = {12'h00A, 10'h200, 10'h0F0};
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0003_0003, 32'hFFFF_FC02);
    run_walk(va, 1'b1, 0);
    expect_fault("R6", 2'd2, 1'b0, 2);
    chk("R3", "inner read addr", g_rd1, inner_at(32'h0003_0003, va));
  endtask

  task automatic t_outer_wprot;
    logic [31:0] va = {12'h7FF, 10'h001, 10'h3FF};
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0006_0001, 32'h0A00_0003);
    run_walk(va, 1'b1, 0);
    expect_fault("R7", 2'd1, 1'b1, 1);
  endtask

  task automatic t_inner_wprot;
    logic [31:0] va = {12'h321, 10'h05A, 10'h077};
    ptbr = 32'h0008_0000;
    map(ptbr, va, 32'h0009_0003, 32'h7777_7401);
    run_walk(va, 1'b1, 0);
    expect_fault("R8", 2'd2, 1'b1, 2);
    run_walk(va, 1'b0, 0);
    expect_ok("R8", va, 32'h0009_0003, 32'h7777_7401);
  endtask

  task automatic t_latency;
    logic [31:0] va = {12'h0C3, 10'h2D2, 10'h1E1};
    ptbr = 32'h0010_0000;
    map(ptbr, va, 32'h0011_0001, 32'h5555_5401);
    gnt_delay = 4; ret_delay = 7;
    run_walk(va, 1'b0, 0);
    expect_ok("R11", va, 32'h0011_0001, 32'h5555_5401);
    gnt_delay = 0; ret_delay = 0;
    run_walk(va, 1'b0, 0);
    expect_ok("R11", va, 32'h0011_0001, 32'h5555_5401);
  endtask

  task automatic t_busy;
    logic [31:0] va = {12'h444, 10'h0FF, 10'h100};
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0002_0001, 32'h2222_2001);
    gnt_delay = 2; ret_delay = 1;
    run_walk(va, 1'b0, 1);
    chk("R9", "not ready while busy", {31'b0, g_busy_ok}, 32'd1);
    chk("R9", "reads with offered request", g_reads, 32'd2);
    chk("R9", "responses with offered request", g_rsps, 32'd1);
    chk("R9", "ready after response", {31'b0, g_back_ready}, 32'd1);
    chk("R9", "paddr of first request", g_paddr, {22'h088888, va[9:0]});
    gnt_delay = 0; ret_delay = 0;
  endtask

  task automatic t_ptbr_change;
    logic [31:0] va = {12'h246, 10'h135, 10'h2F0};
    ptbr = 32'h0020_0000;
    map(ptbr, va, 32'h0021_0001, 32'h3333_3C01);
    ret_delay = 3;
    run_walk(va, 1'b0, 2);
    expect_ok("R12", va, 32'h0021_0001, 32'h3333_3C01);
    ret_delay = 0;
  endtask

  task automatic t_corners;
    logic [31:0] va = 32'hFFFF_FFFF;
    ptbr = 32'h0000_0000;
    map(ptbr, va, 32'hFFF0_0001, 32'hFFFF_FC01);
    run_walk(va, 1'b0, 0);
    expect_ok("R2", va, 32'hFFF0_0001, 32'hFFFF_FC01);
    va = 32'h0;
    ptbr = 32'h0001_0000;
    map(ptbr, va, 32'h0002_0001, 32'h0000_0401);
    run_walk(va, 1'b0, 0);
    expect_ok("R3", va, 32'h0002_0001, 32'h0000_0401);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0; ptbr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_read_ok;
    t_write_ok;
    t_outer_invalid;
    t_inner_invalid;
    t_outer_wprot;
    t_inner_wprot;
    t_latency;
    t_busy;
    t_ptbr_change;
    t_corners;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule